// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank State Tracker

This block sits behind the command pins of a four-bank SDRAM controller model or a memory-side monitor. On every rising clock edge it samples chip select, the three command strobes (row strobe, column strobe, write enable), a 12-bit address and a 2-bit bank address. It turns these into one-cycle command pulses and keeps a record of which banks are open and which row each open bank holds.

Address bit 8 does two jobs. On a precharge it picks between closing every bank and closing only the addressed one. On a read or write it asks for the bank to close by itself once the burst ends. A separate per-bank burst-complete input tells the tracker when that burst has finished. Commands that make no sense for the current bank state are rejected. These are a column access to a closed bank and an activate to an open bank. They raise a one-cycle error pulse instead of a command pulse and change no state. Timing limits, refresh scheduling and data movement are handled elsewhere.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: After reset all banks read closed, no auto-close flag is set, every command pulse and the error pulse are low, and the row, column and bank outputs are zero.
- R2: While cs_n is high the command and address inputs have no effect: no pulse is produced and bank state is kept. Burst-complete handling still runs.
- R3: With cs_n low, {ras_n,cas_n,we_n} decodes as 011 activate, 101 read, 100 write, 010 precharge, 001 refresh and 000 mode set. 111 is no-operation. The matching output pulse is high for exactly the one cycle after the sampling edge.
- R4: A legal activate opens bank {ba[1],ba[0]} (ba[0] is the low bit). It stores addr[11:0] as that bank's row, visible in open_row_o bits [12*b+11:12*b], and drives row_o and bank_o.
- R5: A legal read or write drives col_o with addr[7:0] and bank_o with the addressed bank.
- R6: A precharge with addr[8] low closes only the addressed bank and clears its auto-close flag. A precharge to a closed bank is legal.
- R7: A precharge with addr[8] high closes all four banks, clears all auto-close flags and raises pre_all_o along with pre_o.
- R8: A legal read or write with addr[8] high sets the addressed bank's auto-close flag (ap_o bit b). With addr[8] low the flag is not set.
- R9: burst_done[b] closes bank b and clears its flag only when that flag is set. On a bank without the flag it has no effect. A column access to bank b in the same cycle takes precedence.
- R10: A read or write to a closed bank, or an activate to an open bank, gives err_o high for one cycle, no command pulse and unchanged bank state, rows and flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command sampling clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 12 | Row, column and bit-8 mode address |
| ba | input | 2 | Bank address, ba[0] low bit |
| burst_done | input | 4 | Per-bank burst-finished pulse |
| act_o | output | 1 | Activate accepted |
| rd_o | output | 1 | Read accepted |
| wr_o | output | 1 | Write accepted |
| pre_o | output | 1 | Precharge accepted |
| pre_all_o | output | 1 | Precharge was for all banks |
| ref_o | output | 1 | Refresh decoded |
| mrs_o | output | 1 | Mode set decoded |
| err_o | output | 1 | Illegal command rejected |
| bank_o | output | 2 | Bank of last bank command |
| row_o | output | 12 | Row of last accepted activate |
| col_o | output | 8 | Column of last accepted read or write |
| bank_open_o | output | 4 | Open flag per bank |
| ap_o | output | 4 | Auto-close flag per bank |
| open_row_o | output | 48 | Stored row per bank, bank b at [12b+11:12b] |

## Verification
The bench issues a deselected cycle whose pins spell an activate. A tracker that ignored chip select would open the bank there. It activates an already open bank and reads a closed one. A design missing the legality check would pulse a command and corrupt state. It pulses burst-complete on a bank without the auto-close flag, and then on one with it. This catches a tracker that closes on every pulse or never closes. It also contrasts addr[8] low and high on precharge, where a swapped decode closes the wrong set of banks. Finally it drives burst-complete during a deselected cycle to confirm that internal activity continues while the pins are ignored.

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker #(
  parameter int ROW_W  = 12,
  parameter int COL_W  = 8,
  parameter int AP_BIT = 8,
  parameter int BA_W   = 2,
  localparam int NB    = 1 << BA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_n,
  input  logic                ras_n,
  input  logic                cas_n,
  input  logic                we_n,
  input  logic [ROW_W-1:0]    addr,
  input  logic [BA_W-1:0]     ba,
  input  logic [NB-1:0]       burst_done,
  output logic                act_o,
  output logic                rd_o,
  output logic                wr_o,
  output logic                pre_o,
  output logic                pre_all_o,
  output logic                ref_o,
  output logic                mrs_o,
  output logic                err_o,
  output logic [BA_W-1:0]     bank_o,
  output logic [ROW_W-1:0]    row_o,
  output logic [COL_W-1:0]    col_o,
  output logic [NB-1:0]       bank_open_o,
  output logic [NB-1:0]       ap_o,
  output logic [NB*ROW_W-1:0] open_row_o
);

  logic [2:0] cmd;
  logic is_act, is_rd, is_wr, is_pre, is_ref, is_mrs;
  logic cur_open, act_ok, rw_ok, bad, flag8;

  assign cmd    = {ras_n, cas_n, we_n};
  assign is_act = !cs_n && cmd == 3'b011;
  assign is_rd  = !cs_n && cmd == 3'b101;
  assign is_wr  = !cs_n && cmd == 3'b100;
  assign is_pre = !cs_n && cmd == 3'b010;
  assign is_ref = !cs_n && cmd == 3'b001;
  assign is_mrs = !cs_n && cmd == 3'b000;

  assign flag8    = addr[AP_BIT];
  assign cur_open = bank_open_o[ba];
  assign act_ok   = is_act && !cur_open;
  assign rw_ok    = (is_rd || is_wr) && cur_open;
  assign bad      = (is_act && cur_open) || ((is_rd || is_wr) && !cur_open);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_o     <= 1'b0;
      rd_o      <= 1'b0;
      wr_o      <= 1'b0;
      pre_o     <= 1'b0;
      pre_all_o <= 1'b0;
      ref_o     <= 1'b0;
      mrs_o     <= 1'b0;
      err_o     <= 1'b0;
      bank_o    <= '0;
      row_o     <= '0;
      col_o     <= '0;
    end else begin
      act_o     <= act_ok;
      rd_o      <= is_rd && rw_ok;
      wr_o      <= is_wr && rw_ok;
      pre_o     <= is_pre;
      pre_all_o <= is_pre && flag8;
      ref_o     <= is_ref;
      mrs_o     <= is_mrs;
      err_o     <= bad;
      if (act_ok || rw_ok || is_pre) bank_o <= ba;
      if (act_ok) row_o <= addr;
      if (rw_ok)  col_o <= addr[COL_W-1:0];
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic hit;
    assign hit = (ba == BA_W'(b));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        bank_open_o[b]                 <= 1'b0;
        ap_o[b]                        <= 1'b0;
        open_row_o[b*ROW_W +: ROW_W]   <= '0;
      end else if (is_pre && (flag8 || hit)) begin
        bank_open_o[b] <= 1'b0;
        ap_o[b]        <= 1'b0;
      end else if (act_ok && hit) begin
        bank_open_o[b]               <= 1'b1;
        open_row_o[b*ROW_W +: ROW_W] <= addr;
      end else if (rw_ok && hit) begin
        ap_o[b] <= ap_o[b] | flag8;
      end else if (burst_done[b] && ap_o[b]) begin
        bank_open_o[b] <= 1'b0;
        ap_o[b]        <= 1'b0;
      end
    end
  end

  // R3
  one_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_o, rd_o, wr_o, pre_o, ref_o, mrs_o, err_o}));

  // R2
  deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && burst_done == '0) |=> ($stable(bank_open_o) && $stable(ap_o)
      && !act_o && !rd_o && !wr_o && !pre_o && !err_o));

  // R4
  act_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    act_o |-> bank_open_o[bank_o]);

  // R7
  pre_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_all_o |-> (bank_open_o == '0 && ap_o == '0 && pre_o));

  // R8
  ap_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ap_o & ~bank_open_o) == '0);

  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bad && burst_done == '0) |=> (err_o && $stable(bank_open_o)
      && $stable(ap_o) && $stable(open_row_o)));

endmodule

// File: tb/sdram_cmd_tracker_tb_top.sv
module sdram_cmd_tracker_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [11:0] addr = '0;
  logic [1:0]  ba = '0;
  logic [3:0]  burst_done = '0;
  logic act_o, rd_o, wr_o, pre_o, pre_all_o, ref_o, mrs_o, err_o;
  logic [1:0]  bank_o;
  logic [11:0] row_o;
  logic [7:0]  col_o;
  logic [3:0]  bank_open_o, ap_o;
  logic [47:0] open_row_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  sdram_cmd_tracker dut_i (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .addr(addr), .ba(ba), .burst_done(burst_done),
    .act_o(act_o), .rd_o(rd_o), .wr_o(wr_o), .pre_o(pre_o),
    .pre_all_o(pre_all_o), .ref_o(ref_o), .mrs_o(mrs_o), .err_o(err_o),
    .bank_o(bank_o), .row_o(row_o), .col_o(col_o),
    .bank_open_o(bank_open_o), .ap_o(ap_o), .open_row_o(open_row_o)
  );

  // {cs,ras,cas,we}[36:33] ba[32:31] addr[30:19] bd[18:15] open[14:11] ap[10:7]
  // pulses[6:0] = {act,rd,wr,pre,ref,mrs,err}
  localparam int NV = 18;
  localparam logic [36:0] VEC [NV] = '{
    {4'b0011, 2'd1, 12'hABC, 4'h0, 4'b0010, 4'b0000, 7'b1000000}, // R4
    {4'b0011, 2'd1, 12'h111, 4'h0, 4'b0010, 4'b0000, 7'b0000001}, // R10 act open
    {4'b0101, 2'd2, 12'h010, 4'h0, 4'b0010, 4'b0000, 7'b0000001}, // R10 rd closed
    {4'b1011, 2'd2, 12'h555, 4'h0, 4'b0010, 4'b0000, 7'b0000000}, // R2
    {4'b0011, 2'd2, 12'h123, 4'h0, 4'b0110, 4'b0000, 7'b1000000}, // R4
    {4'b0101, 2'd1, 12'h045, 4'h0, 4'b0110, 4'b0000, 7'b0100000}, // R5 R8 off
    {4'b0100, 2'd2, 12'h177, 4'h0, 4'b0110, 4'b0100, 7'b0010000}, // R8 on
    {4'b0111, 2'd0, 12'h000, 4'h2, 4'b0110, 4'b0100, 7'b0000000}, // R9 no flag
    {4'b0111, 2'd0, 12'h000, 4'h4, 4'b0010, 4'b0000, 7'b0000000}, // R9 close
    {4'b0011, 2'd0, 12'h000, 4'h0, 4'b0011, 4'b0000, 7'b1000000}, // R4
    {4'b0011, 2'd3, 12'hFFF, 4'h0, 4'b1011, 4'b0000, 7'b1000000}, // R4
    {4'b0010, 2'd0, 12'h000, 4'h0, 4'b1010, 4'b0000, 7'b0001000}, // R6
    {4'b0001, 2'd0, 12'h000, 4'h0, 4'b1010, 4'b0000, 7'b0000100}, // R3 ref
    {4'b0000, 2'd0, 12'h000, 4'h0, 4'b1010, 4'b0000, 7'b0000010}, // R3 mrs
    {4'b0101, 2'd3, 12'h1AA, 4'h0, 4'b1010, 4'b1000, 7'b0100000}, // R8
    {4'b0010, 2'd0, 12'h100, 4'h0, 4'b0000, 4'b0000, 7'b0001000}, // R7
    {4'b0100, 2'd0, 12'h000, 4'h0, 4'b0000, 4'b0000, 7'b0000001}, // R10 wr closed
    {4'b0111, 2'd0, 12'h000, 4'h0, 4'b0000, 4'b0000, 7'b0000000}  // R3 nop
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic [1:0] b,
                       input logic [11:0] a, input logic [3:0] bd);
    {cs_n, ras_n, cas_n, we_n} = c;
    ba = b;
    addr = a;
    burst_done = bd;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1 open", {60'd0, bank_open_o}, 64'd0);
    chk("R1 ap", {60'd0, ap_o}, 64'd0);
    chk("R1 pulses", {56'd0, act_o, rd_o, wr_o, pre_o, pre_all_o, ref_o, mrs_o, err_o}, 64'd0);
    chk("R1 addr", {42'd0, bank_o, row_o, col_o}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][36:33], VEC[i][32:31], VEC[i][30:19], VEC[i][18:15]);
      chk($sformatf("R3/R10 vec %0d pulses", i),
          {57'd0, act_o, rd_o, wr_o, pre_o, ref_o, mrs_o, err_o}, {57'd0, VEC[i][6:0]});
      chk($sformatf("R6/R9 vec %0d open", i), {60'd0, bank_open_o}, {60'd0, VEC[i][14:11]});
      chk($sformatf("R8/R9 vec %0d ap", i), {60'd0, ap_o}, {60'd0, VEC[i][10:7]});
    end

    // R7: all-bank precharge flag, plus single precharge leaves it low
    drive(4'b0011, 2'd2, 12'h2B4, 4'h0);
    chk("R4 row_o", {52'd0, row_o}, 64'h2B4);
    chk("R4 bank_o", {62'd0, bank_o}, 64'd2);
    chk("R4 open_row bank2", {52'd0, open_row_o[35:24]}, 64'h2B4);
    drive(4'b0100, 2'd2, 12'h0C3, 4'h0);
    chk("R5 col_o", {56'd0, col_o}, 64'hC3);
    drive(4'b0010, 2'd1, 12'h000, 4'h0);
    chk("R6 pre_all low", {63'd0, pre_all_o}, 64'd0);
    chk("R6 other bank kept", {60'd0, bank_open_o}, 64'b0100);
    drive(4'b0101, 2'd2, 12'h100, 4'h0);
    drive(4'b0010, 2'd3, 12'h100, 4'h0);
    chk("R7 pre_all", {62'd0, pre_o, pre_all_o}, 64'b11);
    chk("R7 all closed", {56'd0, bank_open_o, ap_o}, 64'd0);

    // R2 + R9: deselected cycle still lets a flagged burst close its bank
    drive(4'b0011, 2'd0, 12'h0AA, 4'h0);
    drive(4'b0101, 2'd0, 12'h100, 4'h0);
    chk("R8 flag set", {60'd0, ap_o}, 64'b0001);
    drive(4'b1010, 2'd0, 12'h100, 4'h1);
    chk("R2 R9 close while deselected", {56'd0, bank_open_o, ap_o}, 64'd0);
    chk("R2 no pulse", {63'd0, pre_o}, 64'd0);

    // R9: column access wins over same-cycle burst complete
    drive(4'b0011, 2'd3, 12'h0F0, 4'h0);
    drive(4'b0100, 2'd3, 12'h100, 4'h0);
    drive(4'b0101, 2'd3, 12'h020, 4'h8);
    chk("R9 access wins", {56'd0, bank_open_o, ap_o}, {56'd0, 4'b1000, 4'b1000});
    drive(4'b0111, 2'd0, 12'h000, 4'h8);
    chk("R9 closes after", {60'd0, bank_open_o}, 64'd0);

    // R10: rejected activate leaves stored row
    drive(4'b0011, 2'd1, 12'h321, 4'h0);
    drive(4'b0011, 2'd1, 12'h654, 4'h0);
    chk("R10 err", {63'd0, err_o}, 64'd1);
    chk("R10 row kept", {52'd0, open_row_o[23:12]}, 64'h321);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule